// File: doc/BRIEF.md
# Dword Backend Read Bridge

This block connects a backend that holds 32-bit dwords to a target read port that returns 64-bit quadwords. A read request carries a byte address, eight byte enables aligned to the quadword, a 4-bit tag and an 8-bit control word. The bridge reads one or two dwords from the backend and assembles a quadword-aligned response. The tag and the control word travel back with the data unchanged.

Bit 0 of the control word selects the two-dword case, which covers quadword reads and dword reads that straddle a dword boundary. When that bit is clear, address bit 2 selects which dword is read and which half of the response carries it. The byte strobes sent to the backend are the request's enables for that dword, so a backend whose reads have side effects sees only the requested bytes. A dword whose four enables are all clear is not read at all.

The controller is a six-state machine. `IDLE` accepts a request. `ISSUE_LO` and `ISSUE_HI` each drive a one-cycle backend read for the lower or upper dword. `WAIT_LO` and `WAIT_HI` hold until the backend returns data. `RESPOND` emits the one-cycle response pulse.

The transitions are as follows. On handover, `IDLE` goes to `ISSUE_LO` if the lower dword is needed, otherwise to `ISSUE_HI` if the upper dword is needed, otherwise straight to `RESPOND`. Each `ISSUE_*` state always moves to its `WAIT_*` state. `WAIT_LO` moves on backend valid to `ISSUE_HI` when the upper dword is still needed, otherwise to `RESPOND`. `WAIT_HI` moves on backend valid to `RESPOND`. `RESPOND` always returns to `IDLE`.

Top module: `tgt_rd_dw_bridge`

## Requirements
- R1: `req_ready` is high only in IDLE. It is low from the cycle after a handover until the response pulse has been given.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A `req_valid` seen while `req_ready` is low has no effect on the response or on the backend.
- R3: Single-dword read with address bit 2 equal to 0 and control bit 0 clear. There is one backend read at dword address `{addr[63:3],3'b000}` with strobe `be[3:0]`. The data is returned in `rsp_data[31:0]` and `rsp_data[63:32]` is zero.
- R4: Single-dword read with address bit 2 equal to 1 (control bit 0 is then always clear). There is one backend read at `{addr[63:3],3'b100}` with strobe `be[7:4]`. The data is returned in `rsp_data[63:32]` and `rsp_data[31:0]` is zero.
- R5: With control bit 0 set, the lower dword is read first and the upper dword second. Lower data goes to bits [31:0] and upper data goes to bits [63:32].
- R6: `bk_strb` equals the request's enables for the dword being read. A dword whose four enables are all zero is never read. Every response byte whose enable is clear is zero.
- R7: `rsp_tag` and `rsp_ctl` equal the tag and control word of the accepted request.
- R8: `rsp_valid` is a single-cycle pulse. It comes only after every backend read of the request has returned.
- R9: After reset `req_ready` is high and `rsp_valid` and `bk_rd` are low.
- R10: `bk_rd` lasts one cycle, and no new backend read is issued before `bk_rvalid` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Bridge can take a request |
| req_addr | input | 64 | Request byte address |
| req_be | input | 8 | Quadword-aligned byte enables |
| req_tag | input | 4 | Request tag |
| req_ctl | input | 8 | Control word; bit 0 = two-dword read |
| bk_rd | output | 1 | Backend read strobe, one cycle |
| bk_addr | output | 64 | Dword-aligned backend byte address |
| bk_strb | output | 4 | Backend byte strobes |
| bk_rdata | input | 32 | Backend read data |
| bk_rvalid | input | 1 | Backend read data valid |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 64 | Quadword-aligned response data |
| rsp_tag | output | 4 | Echoed tag |
| rsp_ctl | output | 8 | Echoed control word |

## Verification
The hardest path to reach from the ports is a two-dword request where one half has no enabled bytes. In that case the machine must skip a read and jump past `ISSUE_LO` or `ISSUE_HI` directly.

A close second is a stray `req_valid` arriving while the bridge is busy. The stimulus reaches both on purpose. Directed requests carry control bit 0 together with enables of only `0xF0` or only `0x0F`. After every handover, a junk request with an inverted tag is driven during the busy cycle.

Random requests then mix addresses, sparse enables and backend latencies of 1 to 3 cycles. Every backend access is compared with the expected order and strobe when it occurs.

// File: rtl/tgt_rd_pkg.sv
package tgt_rd_pkg;
    localparam int TAG_W = 4;
    localparam int CTL_W = 8;
    localparam int BE_W  = 8;
    localparam int DW_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_WAIT_LO,
        ST_ISSUE_HI,
        ST_WAIT_HI,
        ST_RESPOND
    } rd_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [CTL_W-1:0] ctl;
        logic [BE_W-1:0]  be;
    } req_meta_t;
endpackage

// File: rtl/tgt_rd_lane_plan.sv
module tgt_rd_lane_plan
    import tgt_rd_pkg::*;
(
    input  logic            dw_sel,
    input  logic            two_dw,
    input  logic [BE_W-1:0] be,
    output logic            need_lo,
    output logic            need_hi
);
    localparam int HALVES = BE_W / DW_BYTES;

    logic [HALVES-1:0] need;

    // A half is read when the request covers it and at least one byte is enabled.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign need[h] = (two_dw || (dw_sel == h[0])) && (|be[h*DW_BYTES +: DW_BYTES]);
    end

    assign need_lo = need[0];
    assign need_hi = need[1];
endmodule

// File: rtl/tgt_rd_fsm.sv
module tgt_rd_fsm
    import tgt_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_fire,
    input  logic      need_lo,
    input  logic      need_hi,
    input  logic      bk_rvalid,
    output rd_state_e state,
    output logic      ready,
    output logic      bk_rd,
    output logic      sel_hi,
    output logic      cap_lo,
    output logic      cap_hi,
    output logic      rsp_valid
);
    rd_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_fire) begin
                if (need_lo)      nxt = ST_ISSUE_LO;
                else if (need_hi) nxt = ST_ISSUE_HI;
                else              nxt = ST_RESPOND;
            end
            ST_ISSUE_LO: nxt = ST_WAIT_LO;
            ST_WAIT_LO:  if (bk_rvalid) nxt = need_hi ? ST_ISSUE_HI : ST_RESPOND;
            ST_ISSUE_HI: nxt = ST_WAIT_HI;
            ST_WAIT_HI:  if (bk_rvalid) nxt = ST_RESPOND;
            ST_RESPOND:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        bk_rd     = 1'b0;
        sel_hi    = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:     ready = 1'b1;
            ST_ISSUE_LO: bk_rd = 1'b1;
            ST_WAIT_LO:  cap_lo = bk_rvalid;
            ST_ISSUE_HI: begin bk_rd = 1'b1; sel_hi = 1'b1; end
            ST_WAIT_HI:  begin sel_hi = 1'b1; cap_hi = bk_rvalid; end
            ST_RESPOND:  rsp_valid = 1'b1;
            default:     ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/tgt_rd_resp_regs.sv
module tgt_rd_resp_regs
    import tgt_rd_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [ADDR_W-1:0] req_addr,
    input  req_meta_t         req_meta,
    input  logic              sel_hi,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [31:0]       bk_rdata,
    output logic [ADDR_W-1:0] hold_addr,
    output req_meta_t         hold_meta,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [3:0]        bk_strb,
    output logic [63:0]       rsp_data
);
    localparam int HALVES = BE_W / DW_BYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_meta <= '0;
        end else if (req_fire) begin
            hold_addr <= req_addr;
            hold_meta <= req_meta;
        end
    end

    logic [HALVES-1:0] cap;
    assign cap = {cap_hi, cap_lo};

    // Each half keeps only its enabled bytes; all lanes clear on a new request.
    for (genvar h = 0; h < HALVES; h++) begin : g_lane
        for (genvar b = 0; b < DW_BYTES; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    rsp_data[(h*DW_BYTES+b)*8 +: 8] <= '0;
                else if (req_fire)
                    rsp_data[(h*DW_BYTES+b)*8 +: 8] <= '0;
                else if (cap[h])
                    rsp_data[(h*DW_BYTES+b)*8 +: 8] <=
                        hold_meta.be[h*DW_BYTES+b] ? bk_rdata[b*8 +: 8] : 8'h00;
            end
        end
    end

    assign bk_addr = {hold_addr[ADDR_W-1:3], sel_hi, 2'b00};
    assign bk_strb = sel_hi ? hold_meta.be[7:4] : hold_meta.be[3:0];
endmodule

// File: rtl/tgt_rd_dw_bridge.sv
module tgt_rd_dw_bridge
    import tgt_rd_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_be,
    input  logic [3:0]        req_tag,
    input  logic [7:0]        req_ctl,
    output logic              bk_rd,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [3:0]        bk_strb,
    input  logic [31:0]       bk_rdata,
    input  logic              bk_rvalid,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic [3:0]        rsp_tag,
    output logic [7:0]        rsp_ctl
);
    rd_state_e         state;
    logic              req_fire, need_lo, need_hi, sel_hi, cap_lo, cap_hi;
    logic [ADDR_W-1:0] hold_addr;
    req_meta_t         hold_meta, in_meta, plan_meta;
    logic              plan_sel;

    assign req_fire = req_valid && req_ready;
    assign in_meta  = '{tag: req_tag, ctl: req_ctl, be: req_be};

    // Plan from the live request at handover, from the held one afterwards.
    assign plan_meta = (state == ST_IDLE) ? in_meta : hold_meta;
    assign plan_sel  = (state == ST_IDLE) ? req_addr[2] : hold_addr[2];

    tgt_rd_lane_plan i_plan (
        .dw_sel  (plan_sel),
        .two_dw  (plan_meta.ctl[0]),
        .be      (plan_meta.be),
        .need_lo (need_lo),
        .need_hi (need_hi)
    );

    tgt_rd_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .need_lo   (need_lo),
        .need_hi   (need_hi),
        .bk_rvalid (bk_rvalid),
        .state     (state),
        .ready     (req_ready),
        .bk_rd     (bk_rd),
        .sel_hi    (sel_hi),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .rsp_valid (rsp_valid)
    );

    tgt_rd_resp_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_addr  (req_addr),
        .req_meta  (in_meta),
        .sel_hi    (sel_hi),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .bk_rdata  (bk_rdata),
        .hold_addr (hold_addr),
        .hold_meta (hold_meta),
        .bk_addr   (bk_addr),
        .bk_strb   (bk_strb),
        .rsp_data  (rsp_data)
    );

    assign rsp_tag = hold_meta.tag;
    assign rsp_ctl = hold_meta.ctl;
endmodule

// File: rtl/tgt_rd_checker.sv
module tgt_rd_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_be,
    input logic [3:0]        req_tag,
    input logic [7:0]        req_ctl,
    input logic              bk_rd,
    input logic [ADDR_W-1:0] bk_addr,
    input logic [3:0]        bk_strb,
    input logic              bk_rvalid,
    input logic              rsp_valid,
    input logic [3:0]        rsp_tag,
    input logic [7:0]        rsp_ctl
);
    logic       c_dw;
    logic [7:0] c_be, c_ctl;
    logic [3:0] c_tag;
    logic       lo_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_dw <= 1'b0; c_be <= '0; c_ctl <= '0; c_tag <= '0; lo_seen <= 1'b0;
        end else if (req_valid && req_ready) begin
            c_dw <= req_addr[2]; c_be <= req_be; c_ctl <= req_ctl; c_tag <= req_tag;
            lo_seen <= 1'b0;
        end else if (bk_rd && !bk_addr[2]) begin
            lo_seen <= 1'b1;
        end
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_rd || rsp_valid) |-> !req_ready);
    a_r10_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd |=> !bk_rd);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r6_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd |-> (bk_strb != 4'h0));
    a_r7_echo: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_tag == c_tag && rsp_ctl == c_ctl));
    a_r4_half_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_rd && !c_ctl[0]) |-> (bk_addr[2] == c_dw));
    a_r5_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_rd && bk_addr[2] && c_ctl[0] && (c_be[3:0] != 4'h0)) |-> lo_seen);
    a_r10_no_stray_data: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd |-> !bk_rvalid);
endmodule

bind tgt_rd_dw_bridge tgt_rd_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_tag   (req_tag),
    .req_ctl   (req_ctl),
    .bk_rd     (bk_rd),
    .bk_addr   (bk_addr),
    .bk_strb   (bk_strb),
    .bk_rvalid (bk_rvalid),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_ctl   (rsp_ctl)
);

// File: tb/test_tgt_rd_dw_bridge.sv
module test_tgt_rd_dw_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [7:0]  req_be = '0;
    logic [3:0]  req_tag = '0;
    logic [7:0]  req_ctl = '0;
    logic        bk_rd;
    logic [63:0] bk_addr;
    logic [3:0]  bk_strb;
    logic [31:0] bk_rdata = '0;
    logic        bk_rvalid = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [3:0]  rsp_tag;
    logic [7:0]  rsp_ctl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tgt_rd_dw_bridge i_tgt_rd_dw_bridge (.*);

    // Expected state for the request in flight.
    logic [63:0] e_data;
    logic [3:0]  e_tag;
    logic [7:0]  e_ctl;
    logic [63:0] e_addr [2];
    logic [3:0]  e_strb [2];
    int          e_n = 0;
    int          acc_idx = 0;
    bit          done = 1'b0;
    bit          prev_rsp = 1'b0;

    function automatic logic [31:0] mem_word(logic [63:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'hC3A5_0F1E ^ a[47:16];
    endfunction

    function automatic bit half_used(logic [63:0] a, logic [7:0] be, logic [7:0] ctl, int h);
        return (ctl[0] || (a[2] == h[0])) && (be[h*4 +: 4] != 4'h0);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Backend model: returns data 1..3 cycles after each strobe.
    bit          pend = 1'b0;
    int          dly = 0;
    logic [63:0] paddr;
    always @(negedge clk) begin
        bk_rvalid <= 1'b0;
        if (pend) begin
            if (dly == 0) begin
                bk_rvalid <= 1'b1;
                bk_rdata  <= mem_word(paddr);
                pend = 1'b0;
            end else dly--;
        end
        if (bk_rd) begin
            if (acc_idx < e_n) begin
                check(bk_addr == e_addr[acc_idx], "R5/R3/R4 backend address", bk_addr, e_addr[acc_idx]);
                check(bk_strb == e_strb[acc_idx], "R6 backend strobe", {60'd0, bk_strb}, {60'd0, e_strb[acc_idx]});
            end else begin
                check(1'b0, "R6/R2 unexpected backend read", bk_addr, 64'd0);
            end
            acc_idx++;
            pend  = 1'b1;
            paddr = bk_addr;
            dly   = int'($urandom % 3);
        end
    end

    // Response monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp && rsp_valid)
                check(1'b0, "R8 pulse longer than one cycle", 64'd1, 64'd0);
            if (rsp_valid) begin
                check(rsp_data == e_data, "R3/R4/R5/R6 response data", rsp_data, e_data);
                check(rsp_tag == e_tag && rsp_ctl == e_ctl, "R7/R2 echoed tag and control",
                      {52'd0, rsp_tag, rsp_ctl}, {52'd0, e_tag, e_ctl});
                check(acc_idx == e_n, "R8 all reads done before response", 64'(acc_idx), 64'(e_n));
                done = 1'b1;
            end
            prev_rsp = rsp_valid;
        end
    end

    task automatic do_req(logic [63:0] a, logic [7:0] be, logic [3:0] tag, logic [7:0] ctl);
        e_n = 0;
        e_data = '0;
        for (int h = 0; h < 2; h++) begin
            if (half_used(a, be, ctl, h)) begin
                e_addr[e_n] = {a[63:3], h[0], 2'b00};
                e_strb[e_n] = be[h*4 +: 4];
                e_n++;
                for (int b = 0; b < 4; b++)
                    if (be[h*4+b]) e_data[(h*4+b)*8 +: 8] = mem_word({a[63:3], h[0], 2'b00})[b*8 +: 8];
            end
        end
        e_tag = tag; e_ctl = ctl;
        acc_idx = 0; done = 1'b0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_be = be; req_tag = tag; req_ctl = ctl;
        @(negedge clk);
        check(!req_ready, "R1 ready low after handover", {63'd0, req_ready}, 64'd0);
        // Stray request while busy must be ignored (R2).
        req_tag = ~tag; req_ctl = ~ctl; req_be = ~be; req_addr = ~a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !bk_rd, "R9 reset state",
              {61'd0, req_ready, rsp_valid, bk_rd}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(64'h0000_0000_0000_1000, 8'h0F, 4'h1, 8'h00);   // R3
        do_req(64'h0000_0000_0000_1004, 8'hF0, 4'h2, 8'h00);   // R4
        do_req(64'h0000_0012_0000_2008, 8'hFF, 4'h3, 8'h01);   // R5
        do_req(64'h0000_0000_0000_300A, 8'h3C, 4'h4, 8'h81);   // R5 crossing
        do_req(64'h0000_0000_0000_3012, 8'h0C, 4'h5, 8'h00);   // R6 partial
        do_req(64'h0000_0000_0000_3014, 8'h30, 4'h6, 8'h00);   // R6 partial upper
        do_req(64'h0000_0000_0000_4000, 8'hF0, 4'h7, 8'h01);   // R6 lower skipped
        do_req(64'h0000_0000_0000_4008, 8'h0F, 4'h8, 8'h01);   // R6 upper skipped
        do_req(64'h0000_0000_0000_5000, 8'h00, 4'h9, 8'h00);   // R6 no read
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic [7:0]  c;
            a = {$urandom, $urandom};
            c = 8'($urandom);
            if (a[2]) c[0] = 1'b0;
            do_req(a, 8'($urandom), 4'($urandom), c);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule